// File: doc/BRIEF.md
# Performance Counter Slot Allocator

This block hands out physical counter slots in a bank of ten performance counters. A client offers one event at a time, tagged with an event identifier and a ten-bit eligibility mask. Bit i of the mask says that slot i can count that event. The allocator grants the lowest-numbered slot that is eligible and free, then marks it busy. One cycle after the request is taken, it reports the granted slot or a conflict. Slots can be freed one at a time or all at once. The occupancy vector and the free-slot count are visible on every cycle.

Slot 0 is meant for the cycle event, with mask bit 0 only. Slot 1 is meant for the retired-instruction event, with mask bit 1 only. The other events use one of three classes:

| Class | Mask | Slots |
|---|---|---|
| General | 0x3FC | 2 to 9 |
| Restricted | 0x0E0 | 5 to 7 |
| Single-slot | 0x080 | 7 only |

Because each grant takes the lowest eligible free slot, the same set of events can succeed or fail depending on the order in which they arrive.

Top module: `pmu_slot_alloc`

## Requirements
- R1: While synchronous active-high `rst` is high, and on the cycle after it, `occupancy` is zero, `free_count` is 10 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. In the next cycle, `rsp_valid` is high for exactly one cycle. `rsp_event` echoes the identifier. If a slot is eligible and free, `rsp_grant` is 1 and `rsp_slot` is the lowest index i with `req_mask[i]`=1 and `occupancy[i]`=0. That bit of `occupancy` is set in the same cycle.
- R3: If no slot in the mask is free, the response has `rsp_conflict`=1, `rsp_grant`=0 and `rsp_slot`=0. `occupancy` is unchanged.
- R4: A request with an all-zero mask always gets a conflict response.
- R5: A request with mask 0x001 takes slot 0, and a request with mask 0x002 takes slot 1, even when slots 2 to 7 are full.
- R6: Order changes the outcome. Six general requests (0x3FC) fill slots 2 to 7, so a later single-slot request (0x080) conflicts. If the single-slot request comes after five general requests, it takes slot 7, and the next general request lands in slot 8.
- R7: Pulsing `rel_valid` with `rel_slot`=i frees slot i on the next edge. Releasing a free slot, or giving an index of 10 or more, leaves `occupancy` unchanged.
- R8: `clear_all` empties every slot on the next edge. While `clear_all` is high, `req_ready` is 0 and no request is accepted.
- R9: `free_count` equals 10 minus the number of set bits in `occupancy` on every cycle.
- R10: Two single-slot (0x080) requests conflict with each other. A fourth restricted (0x0E0) request conflicts once three restricted requests hold slots 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_event | input | 8 | Event identifier |
| req_mask | input | 10 | Eligible slots for the event |
| rel_valid | input | 1 | Free the slot given by `rel_slot` |
| rel_slot | input | 4 | Slot index to free |
| clear_all | input | 1 | Empty all slots |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_grant | output | 1 | A slot was granted |
| rsp_conflict | output | 1 | No eligible slot was free |
| rsp_slot | output | 4 | Granted slot index (0 on conflict) |
| rsp_event | output | 8 | Identifier of the answered request |
| occupancy | output | 10 | Busy slot vector |
| free_count | output | 4 | Number of free slots |

## Verification
The occupancy register holds all of the block's memory, so a wrong internal state shows up on `occupancy` and `free_count` at the first edge after the faulty update. The next grant shows it again: a stale busy bit pushes `rsp_slot` one position higher or turns a grant into a conflict, one cycle after that request. The ordering sequences are used because a priority-select error only changes the result when a narrow mask meets slots already filled by wide-mask events.

// File: rtl/pmu_alloc_pkg.sv
package pmu_alloc_pkg;

    // Kind of response held in the output register
    typedef enum logic [1:0] {
        RSP_NONE     = 2'd0,
        RSP_GRANT    = 2'd1,
        RSP_CONFLICT = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/pmu_lowest_pick.sv
// One-hot select of the lowest set bit of a request vector.
module pmu_lowest_pick #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] cand,
    output logic [WIDTH-1:0] pick,
    output logic             found
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign pick[i]     = cand[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | cand[i];
    end

    assign found = seen[WIDTH];
endmodule

// File: rtl/pmu_onehot_index.sv
// Binary index of a one-hot (or zero) vector.
module pmu_onehot_index #(
    parameter int WIDTH = 10,
    parameter int IDX_W = 4
) (
    input  logic [WIDTH-1:0] onehot,
    output logic [IDX_W-1:0] index
);
    always_comb begin
        index = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (onehot[i]) index = index | IDX_W'(i);
        end
    end
endmodule

// File: rtl/pmu_popcount.sv
// Number of set bits in a vector.
module pmu_popcount #(
    parameter int WIDTH = 10,
    parameter int CNT_W = 4
) (
    input  logic [WIDTH-1:0] bits,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end
endmodule

// File: rtl/pmu_slot_alloc.sv
module pmu_slot_alloc #(
    parameter int NUM_SLOTS = 10,
    parameter int EVENT_W   = 8,
    parameter int IDX_W     = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [EVENT_W-1:0]   req_event,
    input  logic [NUM_SLOTS-1:0] req_mask,
    input  logic                 rel_valid,
    input  logic [IDX_W-1:0]     rel_slot,
    input  logic                 clear_all,
    output logic                 rsp_valid,
    output logic                 rsp_grant,
    output logic                 rsp_conflict,
    output logic [IDX_W-1:0]     rsp_slot,
    output logic [EVENT_W-1:0]   rsp_event,
    output logic [NUM_SLOTS-1:0] occupancy,
    output logic [CNT_W-1:0]     free_count
);
    import pmu_alloc_pkg::*;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] occ;
        rsp_kind_e            kind;
        logic [IDX_W-1:0]     slot;
        logic [EVENT_W-1:0]   event_id;
    } state_t;

    state_t st_d, st_q;

    logic                 accept;
    logic [NUM_SLOTS-1:0] avail;
    logic [NUM_SLOTS-1:0] pick_oh;
    logic                 pick_found;
    logic [IDX_W-1:0]     pick_idx;
    logic [NUM_SLOTS-1:0] rel_oh;
    logic                 rel_in_range;
    logic [CNT_W-1:0]     used_cnt;

    // Eligible and free slots for the offered request
    assign avail = req_mask & ~st_q.occ;

    pmu_lowest_pick #(.WIDTH(NUM_SLOTS)) u_pick (
        .cand  (avail),
        .pick  (pick_oh),
        .found (pick_found)
    );

    pmu_onehot_index #(.WIDTH(NUM_SLOTS), .IDX_W(IDX_W)) u_enc (
        .onehot (pick_oh),
        .index  (pick_idx)
    );

    pmu_popcount #(.WIDTH(NUM_SLOTS), .CNT_W(CNT_W)) u_cnt (
        .bits  (st_q.occ),
        .count (used_cnt)
    );

    assign req_ready    = ~rst & ~clear_all;
    assign accept       = req_valid & req_ready;
    assign rel_in_range = {1'b0, rel_slot} < (IDX_W + 1)'(NUM_SLOTS);
    assign rel_oh       = (rel_valid && rel_in_range) ? (NUM_SLOTS'(1) << rel_slot) : '0;

    always_comb begin
        st_d          = st_q;
        st_d.kind     = RSP_NONE;
        st_d.slot     = '0;
        if (clear_all) begin
            st_d.occ = '0;
        end else begin
            st_d.occ = st_q.occ & ~rel_oh;
            if (accept) begin
                st_d.event_id = req_event;
                if (pick_found) begin
                    st_d.kind = RSP_GRANT;
                    st_d.slot = pick_idx;
                    st_d.occ  = st_d.occ | pick_oh;
                end else begin
                    st_d.kind = RSP_CONFLICT;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{occ: '0, kind: RSP_NONE, slot: '0, event_id: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.kind != RSP_NONE;
    assign rsp_grant    = st_q.kind == RSP_GRANT;
    assign rsp_conflict = st_q.kind == RSP_CONFLICT;
    assign rsp_slot     = st_q.slot;
    assign rsp_event    = st_q.event_id;
    assign occupancy    = st_q.occ;
    assign free_count   = CNT_W'(NUM_SLOTS) - used_cnt;
endmodule

// File: rtl/pmu_slot_alloc_chk.sv
module pmu_slot_alloc_chk #(
    parameter int NUM_SLOTS = 10,
    parameter int EVENT_W   = 8,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [EVENT_W-1:0]   req_event,
    input logic [NUM_SLOTS-1:0] req_mask,
    input logic                 rel_valid,
    input logic [IDX_W-1:0]     rel_slot,
    input logic                 clear_all,
    input logic                 rsp_valid,
    input logic                 rsp_grant,
    input logic                 rsp_conflict,
    input logic [IDX_W-1:0]     rsp_slot,
    input logic [EVENT_W-1:0]   rsp_event,
    input logic [NUM_SLOTS-1:0] occupancy,
    input logic [CNT_W-1:0]     free_count
);
    logic [NUM_SLOTS-1:0] rsp_bit;
    assign rsp_bit = NUM_SLOTS'(1) << rsp_slot;

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (occupancy == '0 && !rsp_valid));

    p_resp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    p_grant_marks_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rel_valid) |=>
            (!rsp_grant || (|(occupancy & rsp_bit) && !(|($past(occupancy) & rsp_bit)))));

    p_conflict_no_change_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rel_valid && (req_mask & ~occupancy) == '0) |=>
            (rsp_conflict && !rsp_grant && $stable(occupancy)));

    p_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mask == '0) |=> rsp_conflict);

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (occupancy == '0 && !rsp_valid));

    p_clear_blocks_ready_r8: assert property (@(posedge clk) disable iff (rst)
        clear_all |-> !req_ready);

    p_free_count_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(free_count) + $countones(occupancy)) == NUM_SLOTS);

    p_grant_conflict_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_conflict));
endmodule

bind pmu_slot_alloc pmu_slot_alloc_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .EVENT_W   (EVENT_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/sim_pmu_slot_alloc.sv
module sim_pmu_slot_alloc;
    localparam int NS = 10;
    localparam int EW = 8;
    localparam int IW = 4;
    localparam int CW = 4;

    localparam logic [NS-1:0] GEN = 10'h3FC;
    localparam logic [NS-1:0] RES = 10'h0E0;
    localparam logic [NS-1:0] ONE = 10'h080;
    localparam logic [NS-1:0] CYC = 10'h001;
    localparam logic [NS-1:0] INS = 10'h002;

    localparam int NV = 26;
    // clear before row, mask, expected grant, expected slot
    localparam logic          V_CLR  [NV] = '{1,0,0,0,0,0,0,0,0, 1,0,0,0,0,0,0,0,0, 1,0,0,0,0, 1,0,0};
    localparam logic [NS-1:0] V_MASK [NV] = '{GEN,GEN,GEN,GEN,GEN,GEN,ONE,CYC,INS,
                                              GEN,GEN,GEN,GEN,GEN,ONE,GEN,GEN,GEN,
                                              RES,RES,RES,RES,ONE,
                                              ONE,ONE,10'h000};
    localparam logic          V_GNT  [NV] = '{1,1,1,1,1,1,0,1,1, 1,1,1,1,1,1,1,1,0, 1,1,1,0,0, 1,0,0};
    localparam int            V_SLOT [NV] = '{2,3,4,5,6,7,0,0,1, 2,3,4,5,6,7,8,9,0, 5,6,7,0,0, 7,0,0};

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [EW-1:0] req_event;
    logic [NS-1:0] req_mask;
    logic          rel_valid;
    logic [IW-1:0] rel_slot;
    logic          clear_all;
    logic          rsp_valid, rsp_grant, rsp_conflict;
    logic [IW-1:0] rsp_slot;
    logic [EW-1:0] rsp_event;
    logic [NS-1:0] occupancy;
    logic [CW-1:0] free_count;

    int checks = 0;
    int errors = 0;
    logic [NS-1:0] model;
    bit done = 0;

    always #5 clk = ~clk;

    pmu_slot_alloc u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_event(req_event), .req_mask(req_mask), .rel_valid(rel_valid),
        .rel_slot(rel_slot), .clear_all(clear_all), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_conflict(rsp_conflict), .rsp_slot(rsp_slot),
        .rsp_event(rsp_event), .occupancy(occupancy), .free_count(free_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int free_of(input logic [NS-1:0] v);
        return NS - $countones(v);
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " occupancy"}, int'(occupancy), int'(model));
        chk({"R9 ", tag, " free_count"}, int'(free_count), free_of(model));
    endtask

    // Offer one request; sample the response one edge later
    task automatic do_req(input logic [NS-1:0] m, input logic [EW-1:0] ev,
                          input logic eg, input int es, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_mask = m; req_event = ev;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_grant"}, int'(rsp_grant), int'(eg));
        chk({tag, " rsp_conflict"}, int'(rsp_conflict), int'(!eg));
        chk({tag, " rsp_slot"}, int'(rsp_slot), es);
        chk({tag, " rsp_event"}, int'(rsp_event), int'(ev));
        if (eg) model[es] = 1'b1;
        check_state(tag);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_all = 1'b1;
        req_valid = 1'b1; req_mask = GEN; req_event = 8'hEE;
        #1 chk("R8 ready low during clear", int'(req_ready), 0);
        @(negedge clk);
        clear_all = 1'b0; req_valid = 1'b0;
        chk("R8 no response to request during clear", int'(rsp_valid), 0);
        model = '0;
        check_state("R8 after clear");
    endtask

    task automatic do_rel(input logic [IW-1:0] s, input string tag);
        @(negedge clk);
        rel_valid = 1'b1; rel_slot = s;
        @(negedge clk);
        rel_valid = 1'b0;
        if (int'(s) < NS) model[s] = 1'b0;
        check_state(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_event = '0; req_mask = '0;
        rel_valid = 1'b0; rel_slot = '0; clear_all = 1'b0;
        model = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 occupancy in reset", int'(occupancy), 0);
        chk("R1 free_count in reset", int'(free_count), NS);
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 occupancy after reset", int'(occupancy), 0);

        // Table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            if (V_CLR[i]) do_clear();
            do_req(V_MASK[i], EW'(i + 16), V_GNT[i], V_SLOT[i],
                   $sformatf("R2/R3/R4/R5/R6/R10 row %0d", i));
        end

        // R2: response lasts a single cycle
        @(negedge clk);
        chk("R2 rsp_valid drops after one cycle", int'(rsp_valid), 0);

        // R7: release behaviour (occupancy now holds slot 7)
        do_rel(4'd7, "R7 release slot 7");
        do_rel(4'd7, "R7 release already free slot");
        do_req(GEN, 8'h55, 1'b1, 2, "R7 refill slot 2");
        do_rel(4'd12, "R7 out-of-range release ignored");
        do_req(GEN, 8'h56, 1'b1, 3, "R7 next general");
        do_rel(4'd2, "R7 release slot 2");
        do_req(GEN, 8'h57, 1'b1, 2, "R7 freed slot reused");

        // R8: clear with occupancy present
        do_clear();

        // R1: reset mid-run
        do_req(CYC, 8'h60, 1'b1, 0, "R5 cycle slot");
        do_req(GEN, 8'h61, 1'b1, 2, "R2 general");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        chk("R1 occupancy after mid-run reset", int'(occupancy), 0);
        chk("R1 rsp_valid after mid-run reset", int'(rsp_valid), 0);
        chk("R1 free_count after mid-run reset", int'(free_count), NS);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule